// File: doc/BRIEF.md
# Tree pseudo-LRU victim selector

This block keeps the replacement state for an 8-way set-associative data cache with 128 sets. The cache uses 32-byte lines, so the 7-bit set index is the physical-address field just above the 5 byte-offset bits. Each set holds a 7-bit binary tree. An allocate request carries a set index, the valid bits of that set's ways and a flush-assist mode flag. The block returns the victim way one cycle later and updates that set's tree. A hit request carries a set index and a way, and it only updates the tree.

In normal mode an empty way is always filled before the tree is consulted. Because of this, a flush done by allocating uniquely addressed lines can need up to 12 allocations per set before every way has been evicted. In flush-assist mode the valid bits are ignored and the tree alone picks the victim. Then 8 back-to-back allocations to one set visit every way exactly once, whatever the starting tree state. A synchronous active-low reset clears every tree.

Top module: `plru_victim_sel`

## Requirements
- R1: While `rstN` is low at a clock edge, every tree bit of every set is cleared to 0 and `victimValid` goes low.
- R2: `victimValid` is high in exactly the cycle after a cycle with `allocReq` high. `victimWay` then shows the victim chosen for that request.
- R3: In normal mode (`flushAssist` low), if any bit of `validBits` is 0, the victim is the lowest-numbered way whose valid bit is 0. Bit i of `validBits` belongs to way i.
- R4: In normal mode with all 8 valid bits at 1, the tree chooses the victim. Tree bits are numbered b0..b6. b0=0 selects ways 0-3 and b0=1 selects ways 4-7. b1 then splits 0-1 (0) from 2-3 (1), and b2 splits 4-5 (0) from 6-7 (1). b3, b4, b5 and b6 pick the lower (0) or higher (1) way of the pairs 0/1, 2/3, 4/5 and 6/7.
- R5: With `flushAssist` high, `validBits` has no effect on the victim, which always comes from the tree.
- R6: In flush-assist mode, starting from an all-zero tree, consecutive allocations to one set return ways 0, 4, 2, 6, 1, 5, 3, 7.
- R7: In flush-assist mode, 8 consecutive allocations to one set return all 8 ways, whatever tree state the set starts in.
- R8: Each access (a hit or an allocation) sets the 3 tree bits on the path to the accessed way so that they point away from it. The other 4 bits of that set are left unchanged.
- R9: An access changes only the tree of its own set.
- R10: If a hit and an allocation name the same set in one cycle, the hit is discarded. If they name different sets, both updates take effect.
- R11: In normal mode, take a set with an all-zero tree where only ways 4 and 5 are valid, and mark each victim valid after it is chosen. The 12th allocation is the first one after which all 8 ways have been chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset of all tree state |
| allocReq | input | 1 | Allocate request: choose a victim and update the tree |
| allocSet | input | 7 | Set index of the allocate request |
| validBits | input | 8 | Valid bit of each way of the allocate set, bit i for way i |
| flushAssist | input | 1 | 1: ignore valid bits and follow the tree only |
| hitReq | input | 1 | Hit request: update the tree only |
| hitSet | input | 7 | Set index of the hit |
| hitWay | input | 3 | Way that hit |
| victimValid | output | 1 | High in the cycle after an allocate request |
| victimWay | output | 3 | Chosen victim way |

## Verification
The only timed result is the victim: it is due exactly one clock edge after the allocate request, and the tree update lands on that same edge. The next request to the same set, one cycle later, therefore already sees the new state. The driver applies each request just after a rising edge and pushes the victim it predicts from its own tree model into a queue. The monitor samples on the following falling edge, where the registered `victimValid` and `victimWay` for that request have settled, and pops and compares one entry. Effects of hit updates, including hits that were discarded, cannot be seen directly, so later allocations to the same set reveal them through the victims they return.

// File: rtl/plru_pkg.sv
package plru_pkg;

  // Strobes sent from the control module to the datapath
  typedef struct packed {
    logic allocEn;   // choose a victim and update the allocate set
    logic hitEn;     // update the hit set
  } plruStrobes_t;

endpackage

// File: rtl/plru_ctrl.sv
module plru_ctrl
  import plru_pkg::*;
#(
  parameter int SET_W = 7
) (
  input  logic             allocReq,
  input  logic [SET_W-1:0] allocSet,
  input  logic             hitReq,
  input  logic [SET_W-1:0] hitSet,
  output plruStrobes_t     strobes
);

  logic sameSet;

  always_comb begin
    sameSet         = (allocSet == hitSet);
    strobes.allocEn = allocReq;
    // R10: an allocation wins over a hit aimed at the same set
    strobes.hitEn   = hitReq && !(allocReq && sameSet);
  end

endmodule

// File: rtl/plru_datapath.sv
module plru_datapath
  import plru_pkg::*;
#(
  parameter int NUM_SETS = 128,
  parameter int NUM_WAYS = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  plruStrobes_t                strobes,
  input  logic [$clog2(NUM_SETS)-1:0] allocSet,
  input  logic [NUM_WAYS-1:0]         validBits,
  input  logic                        flushAssist,
  input  logic [$clog2(NUM_SETS)-1:0] hitSet,
  input  logic [$clog2(NUM_WAYS)-1:0] hitWay,
  output logic                        victimValid,
  output logic [$clog2(NUM_WAYS)-1:0] victimWay
);

  localparam int SET_W  = $clog2(NUM_SETS);
  localparam int WAY_W  = $clog2(NUM_WAYS);
  localparam int TREE_W = NUM_WAYS - 1;

  logic [TREE_W-1:0] treeMem [NUM_SETS];
  logic [TREE_W-1:0] allocTree, hitTree, allocNext, hitNext;
  logic [WAY_W-1:0]  treeWay, lowInvWay, victimNext;
  logic              anyInvalid;

  // Walk from the root (node 0); the children of node n are 2n+1 and 2n+2
  function automatic logic [WAY_W-1:0] walkTree(input logic [TREE_W-1:0] t);
    int node;
    logic [WAY_W-1:0] w;
    node = 0;
    w    = '0;
    for (int lvl = 0; lvl < WAY_W; lvl++) begin
      w    = (w << 1) | WAY_W'(t[node]);
      node = 2 * node + 1 + int'(t[node]);
    end
    return w;
  endfunction

  // Point every node on the path to 'way' away from it (R8)
  function automatic logic [TREE_W-1:0] touchTree(input logic [TREE_W-1:0] t,
                                                   input logic [WAY_W-1:0]  way);
    int node;
    logic dir;
    logic [TREE_W-1:0] r;
    r    = t;
    node = 0;
    for (int lvl = 0; lvl < WAY_W; lvl++) begin
      dir     = way[WAY_W-1-lvl];
      r[node] = ~dir;
      node    = 2 * node + 1 + int'(dir);
    end
    return r;
  endfunction

  always_comb begin
    allocTree = treeMem[allocSet];
    hitTree   = treeMem[hitSet];
    treeWay   = walkTree(allocTree);
  end

  // Lowest-numbered invalid way (R3)
  always_comb begin
    anyInvalid = ~&validBits;
    lowInvWay  = '0;
    for (int i = NUM_WAYS - 1; i >= 0; i--) begin
      if (!validBits[i]) lowInvWay = WAY_W'(i);
    end
  end

  always_comb begin
    victimNext = (flushAssist || !anyInvalid) ? treeWay : lowInvWay;
    allocNext  = touchTree(allocTree, victimNext);
    hitNext    = touchTree(hitTree, hitWay);
  end

  // One tree register per set (R1, R9)
  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    always_ff @(posedge clk) begin
      if (!rstN)                                          treeMem[s] <= '0;
      else if (strobes.allocEn && allocSet == SET_W'(s))  treeMem[s] <= allocNext;
      else if (strobes.hitEn && hitSet == SET_W'(s))      treeMem[s] <= hitNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      victimValid <= 1'b0;
      victimWay   <= '0;
    end else begin
      victimValid <= strobes.allocEn;
      if (strobes.allocEn) victimWay <= victimNext;
    end
  end

  function automatic logic [NUM_WAYS-1:0] belowMask(input logic [WAY_W-1:0] w);
    return (NUM_WAYS'(1) << w) - NUM_WAYS'(1);
  endfunction

  // R2
  alloc_gives_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.allocEn |=> victimValid);

  // R2
  no_alloc_no_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.allocEn |=> !victimValid);

  // R3
  victim_was_invalid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.allocEn && !flushAssist && !(&validBits))
    |=> ((($past(validBits) >> victimWay) & NUM_WAYS'(1)) == '0));

  // R3
  victim_is_lowest_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.allocEn && !flushAssist)
    |=> ((~$past(validBits) & belowMask(victimWay)) == '0));

  // R7
  flush_no_repeat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.allocEn && flushAssist && $past(strobes.allocEn && flushAssist && rstN)
     && allocSet == $past(allocSet))
    |=> victimWay != $past(victimWay));

endmodule

// File: rtl/plru_victim_sel.sv
module plru_victim_sel
  import plru_pkg::*;
#(
  parameter int NUM_SETS = 128,
  parameter int NUM_WAYS = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        allocReq,
  input  logic [$clog2(NUM_SETS)-1:0] allocSet,
  input  logic [NUM_WAYS-1:0]         validBits,
  input  logic                        flushAssist,
  input  logic                        hitReq,
  input  logic [$clog2(NUM_SETS)-1:0] hitSet,
  input  logic [$clog2(NUM_WAYS)-1:0] hitWay,
  output logic                        victimValid,
  output logic [$clog2(NUM_WAYS)-1:0] victimWay
);

  localparam int SET_W = $clog2(NUM_SETS);

  plruStrobes_t strobes;

  plru_ctrl #(.SET_W(SET_W)) ctrl_i (
    .allocReq (allocReq),
    .allocSet (allocSet),
    .hitReq   (hitReq),
    .hitSet   (hitSet),
    .strobes  (strobes)
  );

  plru_datapath #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .allocSet    (allocSet),
    .validBits   (validBits),
    .flushAssist (flushAssist),
    .hitSet      (hitSet),
    .hitWay      (hitWay),
    .victimValid (victimValid),
    .victimWay   (victimWay)
  );

endmodule

// File: tb/plru_victim_sel_tb.sv
module plru_victim_sel_tb_top;

  logic       clk = 1'b0;
  logic       rstN;
  logic       allocReq, flushAssist, hitReq;
  logic [6:0] allocSet, hitSet;
  logic [7:0] validBits;
  logic [2:0] hitWay;
  logic       victimValid;
  logic [2:0] victimWay;

  int vectors  = 0;
  int failures = 0;

  typedef struct {
    logic [2:0] way;
    string      tag;
  } expItem_t;

  expItem_t   expQ[$];
  logic [6:0] mdl [128];
  logic [7:0] seenMask;

  always #5 clk = ~clk;

  plru_victim_sel dut_i (
    .clk(clk), .rstN(rstN), .allocReq(allocReq), .allocSet(allocSet),
    .validBits(validBits), .flushAssist(flushAssist), .hitReq(hitReq),
    .hitSet(hitSet), .hitWay(hitWay), .victimValid(victimValid), .victimWay(victimWay)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference tree: b0 root, b1/b2 middle, b3..b6 pairs (R4)
  function automatic logic [2:0] refTree(input logic [6:0] b);
    if (!b[0]) return !b[1] ? (b[3] ? 3'd1 : 3'd0) : (b[4] ? 3'd3 : 3'd2);
    else       return !b[2] ? (b[5] ? 3'd5 : 3'd4) : (b[6] ? 3'd7 : 3'd6);
  endfunction

  function automatic logic [6:0] refTouch(input logic [6:0] b, input logic [2:0] w);
    logic [6:0] r = b;
    if (w < 4) begin
      r[0] = 1'b1;
      if (w < 2) begin r[1] = 1'b1; r[3] = (w == 0); end
      else       begin r[1] = 1'b0; r[4] = (w == 2); end
    end else begin
      r[0] = 1'b0;
      if (w < 6) begin r[2] = 1'b1; r[5] = (w == 4); end
      else       begin r[2] = 1'b0; r[6] = (w == 6); end
    end
    return r;
  endfunction

  function automatic logic [2:0] refPick(input logic [6:0] b, input logic [7:0] v, input bit f);
    if (!f && v != 8'hFF) begin
      for (int i = 0; i < 8; i++) if (!v[i]) return 3'(i);
    end
    return refTree(b);
  endfunction

  // Driver: one cycle of stimulus, prediction pushed to the scoreboard
  task automatic step(input bit a, input logic [6:0] as, input logic [7:0] v, input bit f,
                      input bit h, input logic [6:0] hs, input logic [2:0] hw,
                      input string tag, output logic [2:0] expWay);
    expItem_t it;
    @(posedge clk); #1;
    allocReq = a; allocSet = as; validBits = v; flushAssist = f;
    hitReq = h; hitSet = hs; hitWay = hw;
    expWay = '0;
    if (a) begin
      expWay  = refPick(mdl[as], v, f);
      it.way  = expWay;
      it.tag  = tag;
      expQ.push_back(it);
      mdl[as] = refTouch(mdl[as], expWay);
    end
    if (h && !(a && hs == as)) mdl[hs] = refTouch(mdl[hs], hw);
  endtask

  task automatic alloc(input logic [6:0] s, input logic [7:0] v, input bit f, input string tag);
    logic [2:0] w;
    step(1'b1, s, v, f, 1'b0, 7'd0, 3'd0, tag, w);
  endtask

  task automatic hit(input logic [6:0] s, input logic [2:0] hw);
    logic [2:0] w;
    step(1'b0, 7'd0, 8'h00, 1'b0, 1'b1, s, hw, "", w);
  endtask

  task automatic idle(input int n);
    logic [2:0] w;
    for (int i = 0; i < n; i++) step(1'b0, 7'd0, 8'h00, 1'b0, 1'b0, 7'd0, 3'd0, "", w);
  endtask

  // Monitor: the registered victim has settled by the falling edge
  always @(negedge clk) begin
    if (rstN === 1'b1 && victimValid === 1'b1) begin
      expItem_t it;
      if (expQ.size() == 0) begin
        check(1'b0, "R2 unexpected victimValid", 1, 0);
      end else begin
        it = expQ.pop_front();
        check(victimWay === it.way, it.tag, int'(victimWay), int'(it.way));
        seenMask = seenMask | (8'd1 << victimWay);
      end
    end
  end

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, failures);
    $finish;
  end

  initial begin
    logic [2:0] w;
    logic [7:0] v;
    logic [2:0] order [8] = '{3'd0, 3'd4, 3'd2, 3'd6, 3'd1, 3'd5, 3'd3, 3'd7};
    expItem_t   it;
    for (int s = 0; s < 128; s++) mdl[s] = '0;
    seenMask = '0;
    rstN = 1'b0; allocReq = 0; allocSet = 0; validBits = 0; flushAssist = 0;
    hitReq = 0; hitSet = 0; hitWay = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(victimValid === 1'b0, "R1 victimValid after reset", int'(victimValid), 0);

    // R1/R6: fresh set, flush-assist order from zero tree
    for (int i = 0; i < 8; i++) begin
      step(1'b1, 7'd5, 8'hFF, 1'b1, 1'b0, 7'd0, 3'd0, "R6 flush order", w);
      check(w == order[i], "R6 reference order", int'(w), int'(order[i]));
    end
    alloc(7'd127, 8'hFF, 1'b0, "R1 reset tree picks way 0");
    idle(2);
    check(expQ.size() == 0, "R2 all victims returned", expQ.size(), 0);

    // R3: invalid-first in normal mode
    alloc(7'd10, 8'hFE, 1'b0, "R3 way0 invalid");
    alloc(7'd10, 8'hF7, 1'b0, "R3 way3 invalid");
    alloc(7'd10, 8'h7F, 1'b0, "R3 way7 invalid");
    alloc(7'd10, 8'h00, 1'b0, "R3 all invalid");
    alloc(7'd10, 8'h5A, 1'b0, "R3 mixed");
    // R4: all valid, tree decides
    alloc(7'd10, 8'hFF, 1'b0, "R4 tree pick");
    alloc(7'd10, 8'hFF, 1'b0, "R4 tree pick 2");
    // R5: flush ignores valid bits
    alloc(7'd10, 8'h00, 1'b1, "R5 flush ignores valid");
    alloc(7'd10, 8'h0F, 1'b1, "R5 flush ignores valid 2");
    idle(2);

    // R8/R9: hits on set 20 leave set 21 alone
    hit(7'd20, 3'd3);
    hit(7'd20, 3'd6);
    alloc(7'd20, 8'hFF, 1'b1, "R8 hit path bits");
    alloc(7'd21, 8'hFF, 1'b1, "R9 neighbour set untouched");
    hit(7'd22, 3'd0);
    alloc(7'd22, 8'hFF, 1'b1, "R8 hit way0 redirects");
    idle(2);

    // R10: same-set hit dropped, different-set hit kept
    step(1'b1, 7'd30, 8'hFF, 1'b1, 1'b1, 7'd30, 3'd4, "R10 same set alloc", w);
    alloc(7'd30, 8'hFF, 1'b1, "R10 dropped hit invisible");
    step(1'b1, 7'd31, 8'hFF, 1'b1, 1'b1, 7'd32, 3'd1, "R10 diff set alloc", w);
    alloc(7'd32, 8'hFF, 1'b1, "R10 diff set hit applied");
    idle(2);

    // R7: coverage from arbitrary start states
    hit(7'd60, 3'd5); hit(7'd60, 3'd2); hit(7'd60, 3'd7);
    idle(2);
    seenMask = '0;
    for (int i = 0; i < 8; i++) alloc(7'd60, 8'h00, 1'b1, "R7 flush cover");
    idle(2);
    check(seenMask == 8'hFF, "R7 all ways set 60", int'(seenMask), 255);
    hit(7'd61, 3'd3); hit(7'd61, 3'd6); hit(7'd61, 3'd0);
    idle(2);
    seenMask = '0;
    for (int i = 0; i < 8; i++) alloc(7'd61, 8'hFF, 1'b1, "R7 flush cover");
    idle(2);
    check(seenMask == 8'hFF, "R7 all ways set 61", int'(seenMask), 255);

    // R11: worst-case normal-mode fill
    seenMask = '0;
    v = 8'h30;
    for (int i = 0; i < 11; i++) begin
      step(1'b1, 7'd40, v, 1'b0, 1'b0, 7'd0, 3'd0, "R11 fill", w);
      v = v | (8'd1 << w);
    end
    idle(2);
    check(seenMask != 8'hFF, "R11 incomplete after 11", int'(seenMask), 223);
    step(1'b1, 7'd40, v, 1'b0, 1'b0, 7'd0, 3'd0, "R11 fill 12th", w);
    idle(2);
    check(seenMask == 8'hFF, "R11 complete after 12", int'(seenMask), 255);

    // R1: reset again clears trees mid-run
    @(posedge clk); #1 rstN = 1'b0;
    for (int s = 0; s < 128; s++) mdl[s] = '0;
    @(posedge clk); #1 rstN = 1'b1;
    @(negedge clk);
    check(victimValid === 1'b0, "R1 victimValid after second reset", int'(victimValid), 0);
    alloc(7'd20, 8'hFF, 1'b1, "R1 tree cleared");
    alloc(7'd60, 8'hFF, 1'b0, "R1 tree cleared 2");
    idle(3);
    check(expQ.size() == 0, "R2 queue drained", expQ.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, failures);
    $finish;
  end

endmodule